// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a down-counting interval timer with a small register window on a plain 32-bit read/write bus. Software programs a start value, a match value and a set of control options. From these the block works as a free-running time base, a periodic event source that reloads itself, or a one-shot source that software stops from its interrupt handler. The counter steps once on each strobe of the chosen tick source. Three tick-enable inputs stand for the selectable clock sources, and a two-bit field picks one of them or none.

When the counter reaches the match value, a sticky flag is set. Software clears the flag by writing a one to it. The interrupt line is that flag, gated by an enable bit. A self-clearing soft reset returns the counter, the flag and the run bits to idle and keeps the mode options. Three mode inputs (debug, wait, stop) can freeze the counter unless the matching run-permit bit is set.

Top module: `irq_down_timer`

## Requirements
- R1: Registers sit at byte offsets control 0x00, status 0x04, start value 0x08, match value 0x0C and counter 0x10 (read-only). The start and match registers read back what was written. Any other offset reads as zero. After reset every register reads zero.
- R2: While control bit 0 is set, the counter goes down by exactly one on each strobe of the selected tick source.
- R3: Control bits 25:24 select the tick source: 0 none, 1 `tick_pclk`, 2 `tick_hfref`, 3 `tick_lfclk`. Strobes on a source that is not selected have no effect.
- R4: When a control write changes bit 0 from 0 to 1 and also sets bit 1, the counter loads the start value. If bit 1 is clear, or if bit 0 was already set, the counter keeps its value.
- R5: While control bit 0 is clear, the counter holds its value.
- R6: A counting step from zero loads the start value when control bit 3 is set. When bit 3 is clear, the counter wraps to all ones.
- R7: Status bit 0 sets on a counting step whose new counter value equals the match value. Writing 1 to status bit 0 clears it, even while the timer is disabled. Writing 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R8: Writing control bit 16 starts a soft reset. Bit 16 reads 1 for `SRST_CYCLES` cycles and then clears by itself. Afterwards the counter and status read 0, control bits 0 and 2 are cleared, and bits 1, 3, 17, 18, 19, 21 and 25:24 are kept. Bus writes during the soft reset are ignored.
- R9: With control bit 17 set, a write to the start register also puts the written value into the counter at once. With bit 17 clear, the counter is not touched by that write.
- R10: While `dbg_mode`, `wait_mode` or `stop_mode` is high and its permit bit (18, 19 or 21 respectively) is clear, the counter holds. With the permit bit set, that mode input does not stop counting.
- R11: `irq` is high exactly when status bit 0 and control bit 2 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_pclk | input | 1 | Tick strobe, source 1 |
| tick_hfref | input | 1 | Tick strobe, source 2 |
| tick_lfclk | input | 1 | Tick strobe, source 3 |
| dbg_mode | input | 1 | Debug mode indication |
| wait_mode | input | 1 | Wait mode indication |
| stop_mode | input | 1 | Stop mode indication |
| irq | output | 1 | Match interrupt |

## Verification
A counting step that lands on the match value can fall in the same cycle as a software write that clears the match flag. This is the race a handler meets when it acknowledges one event while the next one arrives. The bench sets the flag, moves the match value one below the counter, and then drives a tick strobe and a status clear write in the same cycle. The flag must read as set afterwards, and a later clear with no tick must drop it. A second overlap, a start-register write with overwrite enabled against a running counter, is covered by the rule that the bus value wins over the step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned REG_W = 32;

   // Register byte offsets
   localparam int unsigned OFS_CTRL = 'h00;
   localparam int unsigned OFS_STAT = 'h04;
   localparam int unsigned OFS_LOAD = 'h08;
   localparam int unsigned OFS_CMP  = 'h0C;
   localparam int unsigned OFS_CNT  = 'h10;

   // Control bit positions
   localparam int unsigned B_EN    = 0;
   localparam int unsigned B_ENLD  = 1;
   localparam int unsigned B_IEN   = 2;
   localparam int unsigned B_RLD   = 3;
   localparam int unsigned B_SRST  = 16;
   localparam int unsigned B_OVW   = 17;
   localparam int unsigned B_DBG   = 18;
   localparam int unsigned B_WAIT  = 19;
   localparam int unsigned B_STOP  = 21;
   localparam int unsigned B_CS_LO = 24;
   localparam int unsigned CS_W    = 2;

   // Writable bits, and bits that survive a soft reset
   localparam logic [REG_W-1:0] CTRL_WMASK = 32'h032F_000F;
   localparam logic [REG_W-1:0] CTRL_KEEP  = 32'h032E_000A;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
   parameter int unsigned SEL_W = 2
) (
   input  logic [SEL_W-1:0]         sel,
   input  logic [(1<<SEL_W)-1:0]    src,
   output logic                     tick
);
   localparam int unsigned NSRC = 1 << SEL_W;

   initial begin
      if (SEL_W < 1 || SEL_W > 4) $error("tmr_tick_sel: SEL_W out of range");
   end

   logic [NSRC-1:0] gated;

   generate
      for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
         assign gated[gi] = src[gi] & (sel == SEL_W'(gi));
      end
   endgenerate

   assign tick = |gated;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SRST_CYCLES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [REG_W-1:0]    wdata,
   input  logic                hit,
   output logic [REG_W-1:0]    ctrl_q,
   output logic [CNT_W-1:0]    load_q,
   output logic [CNT_W-1:0]    cmp_q,
   output logic                flag_q,
   output logic                srst,
   output logic                en_load,
   output logic                ovw_load
);
   localparam int unsigned SR_W = $clog2(SRST_CYCLES + 1);

   logic [SR_W-1:0] sr_cnt;
   logic wr_ctrl, wr_stat, wr_load, wr_cmp;

   assign srst    = ctrl_q[B_SRST];
   assign wr_ctrl = we & !srst & (addr == ADDR_W'(OFS_CTRL));
   assign wr_stat = we & !srst & (addr == ADDR_W'(OFS_STAT));
   assign wr_load = we & !srst & (addr == ADDR_W'(OFS_LOAD));
   assign wr_cmp  = we & !srst & (addr == ADDR_W'(OFS_CMP));

   assign en_load  = wr_ctrl & wdata[B_EN] & !ctrl_q[B_EN]
                   & wdata[B_ENLD] & !wdata[B_SRST];
   assign ovw_load = wr_load & ctrl_q[B_OVW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sr_cnt <= '0;
      end else if (srst) begin
         if (sr_cnt <= SR_W'(1)) begin
            ctrl_q <= ctrl_q & CTRL_KEEP;
            sr_cnt <= '0;
         end else begin
            sr_cnt <= sr_cnt - SR_W'(1);
         end
      end else if (wr_ctrl) begin
         ctrl_q <= wdata & CTRL_WMASK;
         if (wdata[B_SRST]) sr_cnt <= SR_W'(SRST_CYCLES);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (wr_load) load_q <= wdata[CNT_W-1:0];
         if (wr_cmp)  cmp_q  <= wdata[CNT_W-1:0];
      end
   end

   // Set beats clear when both arrive in one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_q <= 1'b0;
      else if (srst)              flag_q <= 1'b0;
      else if (hit)               flag_q <= 1'b1;
      else if (wr_stat & wdata[0]) flag_q <= 1'b0;
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              step,
   input  logic              rld,
   input  logic              en_load,
   input  logic              ovw_load,
   input  logic [CNT_W-1:0]  ovw_val,
   input  logic [CNT_W-1:0]  load_q,
   input  logic [CNT_W-1:0]  cmp_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              hit
);
   logic [CNT_W-1:0] nxt;

   always_comb begin
      if (cnt_q == '0) nxt = rld ? load_q : '1;
      else             nxt = cnt_q - CNT_W'(1);
   end

   assign hit = step & !srst & !ovw_load & !en_load & (nxt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (srst)     cnt_q <= '0;
      else if (ovw_load) cnt_q <= ovw_val;
      else if (en_load)  cnt_q <= load_q;
      else if (step)     cnt_q <= nxt;
   end
endmodule

// File: rtl/irq_down_timer.sv
module irq_down_timer
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SRST_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               tick_pclk,
   input  logic               tick_hfref,
   input  logic               tick_lfclk,
   input  logic               dbg_mode,
   input  logic               wait_mode,
   input  logic               stop_mode,
   output logic               irq
);
   initial begin
      if (ADDR_W < 5)                 $error("irq_down_timer: ADDR_W must be at least 5");
      if (CNT_W < 8 || CNT_W > REG_W) $error("irq_down_timer: CNT_W out of range");
      if (SRST_CYCLES < 1)            $error("irq_down_timer: SRST_CYCLES must be at least 1");
   end

   logic [REG_W-1:0] ctrl_q;
   logic [CNT_W-1:0] load_q, cmp_q, cnt_q;
   logic flag_q, srst, en_load, ovw_load, hit, tick_sel, frozen, step;
   logic [REG_W-1:0] cnt_rd, load_rd, cmp_rd;

   tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SRST_CYCLES(SRST_CYCLES)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit), .ctrl_q(ctrl_q), .load_q(load_q), .cmp_q(cmp_q), .flag_q(flag_q),
      .srst(srst), .en_load(en_load), .ovw_load(ovw_load)
   );

   tmr_tick_sel #(.SEL_W(CS_W)) u_tsel (
      .sel(ctrl_q[B_CS_LO +: CS_W]),
      .src({tick_lfclk, tick_hfref, tick_pclk, 1'b0}),
      .tick(tick_sel)
   );

   assign frozen = (dbg_mode  & !ctrl_q[B_DBG])
                 | (wait_mode & !ctrl_q[B_WAIT])
                 | (stop_mode & !ctrl_q[B_STOP]);
   assign step   = tick_sel & ctrl_q[B_EN] & !frozen & !srst;

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .srst(srst), .step(step), .rld(ctrl_q[B_RLD]),
      .en_load(en_load), .ovw_load(ovw_load), .ovw_val(bus_wdata[CNT_W-1:0]),
      .load_q(load_q), .cmp_q(cmp_q), .cnt_q(cnt_q), .hit(hit)
   );

   generate
      if (CNT_W == REG_W) begin : g_full
         assign cnt_rd  = cnt_q;
         assign load_rd = load_q;
         assign cmp_rd  = cmp_q;
      end else begin : g_pad
         assign cnt_rd  = {{(REG_W-CNT_W){1'b0}}, cnt_q};
         assign load_rd = {{(REG_W-CNT_W){1'b0}}, load_q};
         assign cmp_rd  = {{(REG_W-CNT_W){1'b0}}, cmp_q};
      end
   endgenerate

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_CTRL): bus_rdata = ctrl_q;
         ADDR_W'(OFS_STAT): bus_rdata = {31'd0, flag_q};
         ADDR_W'(OFS_LOAD): bus_rdata = load_rd;
         ADDR_W'(OFS_CMP):  bus_rdata = cmp_rd;
         ADDR_W'(OFS_CNT):  bus_rdata = cnt_rd;
         default:           bus_rdata = '0;
      endcase
   end

   assign irq = flag_q & ctrl_q[B_IEN];
endmodule

// File: rtl/tmr_sva.sv
module tmr_sva #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  load_q,
   input logic              rld,
   input logic              en,
   input logic              frozen,
   input logic              ovw_load,
   input logic              en_load,
   input logic              srst,
   input logic              flag_q,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wd0
);
   logic stat_clr;
   assign stat_clr = bus_we & bus_wd0 & (bus_addr == ADDR_W'(4));

   AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      step && cnt_q != '0 && !ovw_load |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))); // R2
   AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step && cnt_q == '0 && !rld && !ovw_load |=> cnt_q == '1); // R6
   AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      step && cnt_q == '0 && rld && !ovw_load |=> cnt_q == $past(load_q)); // R6
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !ovw_load && !en_load && !srst |=> $stable(cnt_q)); // R5
   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      frozen && !ovw_load && !en_load && !srst |=> $stable(cnt_q)); // R10
   AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> cnt_q == '0 && !flag_q); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !stat_clr && !srst |=> flag_q); // R7
endmodule

bind irq_down_timer tmr_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .step(step), .cnt_q(cnt_q), .load_q(load_q),
   .rld(ctrl_q[3]), .en(ctrl_q[0]), .frozen(frozen), .ovw_load(ovw_load),
   .en_load(en_load), .srst(srst), .flag_q(flag_q), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wd0(bus_wdata[0])
);

// File: tb/sim_irq_down_timer.sv
`timescale 1ns/1ps
module sim_irq_down_timer;
   localparam int unsigned AW = 5;
   localparam logic [AW-1:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                             A_CMP = 5'h0C, A_CNT = 5'h10, A_NONE = 5'h14;

   logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic tick_pclk = 0, tick_hfref = 0, tick_lfclk = 0;
   logic dbg_mode = 0, wait_mode = 0, stop_mode = 0, irq;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_down_timer #(.ADDR_W(AW), .CNT_W(32), .SRST_CYCLES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_pclk(tick_pclk),
      .tick_hfref(tick_hfref), .tick_lfclk(tick_lfclk), .dbg_mode(dbg_mode),
      .wait_mode(wait_mode), .stop_mode(stop_mode), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic tick(input int src, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_pclk = (src == 1); tick_hfref = (src == 2); tick_lfclk = (src == 3);
         @(negedge clk);
         tick_pclk = 0; tick_hfref = 0; tick_lfclk = 0;
      end
   endtask

   task automatic chk_reg(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      chk_reg("R1 reset ctrl", A_CTRL, 0);
      chk_reg("R1 reset stat", A_STAT, 0);
      chk_reg("R1 reset cnt", A_CNT, 0);
      check("R11 reset irq", {31'd0, irq}, 0);
   endtask

   task automatic t_map();
      wr(A_LOAD, 32'h0000_1234); wr(A_CMP, 32'h0000_ABCD);
      chk_reg("R1 load readback", A_LOAD, 32'h1234);
      chk_reg("R1 cmp readback", A_CMP, 32'hABCD);
      chk_reg("R1 unmapped", A_NONE, 0);
   endtask

   task automatic t_count_select();
      wr(A_LOAD, 100);
      wr(A_CTRL, 32'h0100_0003);
      chk_reg("R4 load on enable", A_CNT, 100);
      tick(1, 5);
      chk_reg("R2 decrement", A_CNT, 95);
      tick(2, 3); tick(3, 2);
      chk_reg("R3 unselected ignored", A_CNT, 95);
      wr(A_CTRL, 32'h0200_0003);
      chk_reg("R4 no reload when already on", A_CNT, 95);
      tick(2, 2);
      chk_reg("R3 select 2", A_CNT, 93);
      wr(A_CTRL, 32'h0300_0003); tick(3, 1);
      chk_reg("R3 select 3", A_CNT, 92);
      wr(A_CTRL, 32'h0000_0003); tick(1, 1); tick(2, 1); tick(3, 1);
      chk_reg("R3 select 0 off", A_CNT, 92);
   endtask

   task automatic t_disable();
      wr(A_CTRL, 32'h0100_0000); tick(1, 3);
      chk_reg("R5 hold while disabled", A_CNT, 92);
      wr(A_CTRL, 32'h0100_0001);
      chk_reg("R4 enable without load bit", A_CNT, 92);
      wr(A_CTRL, 32'h0100_0000);
   endtask

   task automatic t_zero();
      wr(A_CTRL, 0); wr(A_LOAD, 2); wr(A_CMP, 32'h8000_0000);
      wr(A_CTRL, 32'h0100_000B); tick(1, 3);
      chk_reg("R6 reload at zero", A_CNT, 2);
      wr(A_CTRL, 0); wr(A_LOAD, 1);
      wr(A_CTRL, 32'h0100_0003); tick(1, 2);
      chk_reg("R6 wrap at zero", A_CNT, 32'hFFFF_FFFF);
   endtask

   task automatic t_flag();
      wr(A_CTRL, 0); wr(A_STAT, 1);
      wr(A_LOAD, 7); wr(A_CMP, 5);
      wr(A_CTRL, 32'h0100_0007); tick(1, 1);
      chk_reg("R7 no flag before match", A_STAT, 0);
      tick(1, 1);
      chk_reg("R7 flag on match", A_STAT, 1);
      check("R11 irq with enable", {31'd0, irq}, 1);
      wr(A_STAT, 0);
      chk_reg("R7 write zero no effect", A_STAT, 1);
      wr(A_CTRL, 32'h0100_0001);
      check("R11 irq gated off", {31'd0, irq}, 0);
      wr(A_CTRL, 32'h0100_0004); wr(A_STAT, 1);
      chk_reg("R7 clear while disabled", A_STAT, 0);
      check("R11 irq low after clear", {31'd0, irq}, 0);
      // collision: match step and clear write in one cycle
      wr(A_CTRL, 0); wr(A_LOAD, 50); wr(A_CMP, 49);
      wr(A_CTRL, 32'h0100_0003); tick(1, 1);
      chk_reg("R7 flag set before race", A_STAT, 1);
      wr(A_CMP, 48);
      @(negedge clk); bus_we = 1; bus_addr = A_STAT; bus_wdata = 1; tick_pclk = 1;
      @(negedge clk); bus_we = 0; tick_pclk = 0;
      chk_reg("R7 set wins over clear", A_STAT, 1);
      chk_reg("R7 count in race", A_CNT, 48);
      wr(A_STAT, 1);
      chk_reg("R7 later clear", A_STAT, 0);
   endtask

   task automatic t_overwrite();
      wr(A_CTRL, 32'h0102_0000); wr(A_LOAD, 32'h50);
      chk_reg("R9 overwrite on load write", A_CNT, 32'h50);
      wr(A_CTRL, 32'h0100_0000); wr(A_LOAD, 32'h77);
      chk_reg("R9 no overwrite when off", A_CNT, 32'h50);
   endtask

   task automatic t_freeze();
      wr(A_CMP, 32'h8000_0000);
      wr(A_CTRL, 32'h0100_0001);
      dbg_mode = 1; tick(1, 1);
      chk_reg("R10 debug freeze", A_CNT, 32'h50);
      wr(A_CTRL, 32'h0104_0001); tick(1, 1);
      chk_reg("R10 debug permitted", A_CNT, 32'h4F);
      dbg_mode = 0; wait_mode = 1;
      wr(A_CTRL, 32'h0100_0001); tick(1, 1);
      chk_reg("R10 wait freeze", A_CNT, 32'h4F);
      wr(A_CTRL, 32'h0108_0001); tick(1, 1);
      chk_reg("R10 wait permitted", A_CNT, 32'h4E);
      wait_mode = 0; stop_mode = 1;
      wr(A_CTRL, 32'h0100_0001); tick(1, 1);
      chk_reg("R10 stop freeze", A_CNT, 32'h4E);
      wr(A_CTRL, 32'h0120_0001); tick(1, 1);
      chk_reg("R10 stop permitted", A_CNT, 32'h4D);
      stop_mode = 0;
   endtask

   task automatic t_srst();
      logic [31:0] v;
      int polls;
      wr(A_CMP, 32'h4C); tick(1, 1);
      chk_reg("R8 flag set before reset", A_STAT, 1);
      wr(A_CTRL, 32'h0109_000D);
      rd(A_CTRL, v);
      check("R8 busy bit set", {31'd0, v[16]}, 1);
      wr(A_LOAD, 32'hDEAD);
      polls = 0;
      do begin rd(A_CTRL, v); polls++; end while (v[16] && polls < 50);
      check("R8 busy self-clears", {31'd0, v[16]}, 0);
      check("R8 mode bits kept", v, 32'h0108_0008);
      chk_reg("R8 counter cleared", A_CNT, 0);
      chk_reg("R8 status cleared", A_STAT, 0);
      chk_reg("R8 write ignored while busy", A_LOAD, 32'h77);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_count_select();
      t_disable();
      t_zero();
      t_flag();
      t_overwrite();
      t_freeze();
      t_srst();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule